// File: doc/BRIEF.md
# Write-Protect Command Sequence Guard

This block sits behind the page-write front end of a byte-wide non-volatile memory. It sees every qualified write strobe as an address and data pair, recognises two fixed command sequences in that stream, and keeps a software write-protect flag. A three-write prefix arms protection and also authorises the load that follows it. A six-write sequence clears protection and likewise opens the load that follows it. Command bytes are flagged in the cycle of their strobe so the page buffer drops them instead of latching them.

Consecutive command writes must arrive within the same byte-load window as page data. An internal window timer restarts on every strobe. When the window runs out, the load period ends and the detector falls back to idle. A change to the protect flag is held pending and applied only when the programming timer reports the end of the write period. This holds even when no data byte followed the command. A write made while protection is on and no prefix came first loads nothing into the array.

Top module: `wp_seq_guard`

## Requirements
- R1: Out of reset `protect_on` is 0 and `load_permit` is 1, and `cmd_byte` and `byte_store` stay 0 while `wr_stb` is 0.
- R2: The arming prefix is 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. Each of these strobes raises `cmd_byte` in its own cycle and never raises `byte_store`. A command byte always has address 0x5555 or 0x2AAA and data 0xAA, 0x55, 0xA0, 0x80 or 0x20.
- R3: After a complete arming prefix, `protect_on` stays 0 until the next `wp_done` pulse. It reads 1 in the cycle after that pulse, even if no data byte was loaded. `protect_on` never changes except in the cycle after a `wp_done` pulse.
- R4: While `protect_on` is 1 and no prefix has been seen in the current load, `load_permit` is 0 and a strobe gives `byte_store` = 0 and `cmd_byte` = 0 (unless the byte begins a command).
- R5: While protected, once the prefix completes, `load_permit` is 1 from the next cycle. Every further strobe in that load period gives `byte_store` = 1 and `cmd_byte` = 0, even for bytes that match a command.
- R6: The clearing sequence is 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. All six bytes are command bytes. Bytes loaded after it are stored. `protect_on` goes to 0 in the cycle after the next `wp_done`.
- R7: A strobe that does not match the expected next step returns the detector to idle and is treated as an ordinary byte. The exception is a mismatching 0xAA@0x5555, which is a command byte and counts as step one of a new sequence.
- R8: A strobe that comes WINDOW_CYCLES cycles after the previous one still belongs to the same load period. If no strobe comes within WINDOW_CYCLES cycles, the load period ends: the sequence returns to idle and any authorisation lapses, so `load_permit` equals the inverse of `protect_on`.
- R9: While `protect_on` is 0, every strobe that is not a command byte gives `byte_store` = 1.
- R10: A `wp_done` pulse in the same cycle as the strobe that completes a command does not apply that command. It is applied at the following `wp_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_stb | input | 1 | One-cycle pulse per qualified write byte |
| wr_addr | input | ADDR_W | Address of the write byte |
| wr_data | input | 8 | Data of the write byte |
| wp_done | input | 1 | Pulse at the end of the internal write period |
| cmd_byte | output | 1 | Current strobe is part of a command sequence |
| byte_store | output | 1 | Current strobe may be latched for the array |
| load_permit | output | 1 | Current load period may write the array |
| protect_on | output | 1 | Software write-protect flag |

## Verification
Two pairs of events can land in the same cycle. The first pair is a new strobe and the expiry of the byte-load window. A command step sent exactly WINDOW_CYCLES cycles after the previous one must still advance the sequence, while one cycle later it must be ignored. The bench checks this through `cmd_byte` and `byte_store`. The second pair is an end-of-write pulse and the strobe that completes the clearing sequence. The bench drives `wp_done` during the final 0x20 byte and checks that `protect_on` holds through that edge and falls only at the next pulse.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

  // sequence position
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_K1,
    ST_K2,
    ST_D3,
    ST_D4,
    ST_D5,
    ST_DATA
  } step_t;

  // classified byte
  typedef enum logic [2:0] {
    TK_OTHER,
    TK_KEY1,
    TK_KEY2,
    TK_GRANT,
    TK_EXT,
    TK_DROP
  } tok_t;

  localparam logic [7:0] KEY1_DATA  = 8'hAA;
  localparam logic [7:0] KEY2_DATA  = 8'h55;
  localparam logic [7:0] GRANT_DATA = 8'hA0;
  localparam logic [7:0] EXT_DATA   = 8'h80;
  localparam logic [7:0] DROP_DATA  = 8'h20;

  // ones on even bit positions below w
  function automatic logic [63:0] alt_ones(input int w);
    logic [63:0] v;
    v = '0;
    for (int i = 0; i < w; i += 2) v[i] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/wpg_classify.sv
module wpg_classify
  import wpg_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  output tok_t              tok
);
  localparam logic [63:0]       ALT    = alt_ones(ADDR_W);
  localparam logic [ADDR_W-1:0] ADDR_A = ALT[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] ADDR_B = ~ADDR_A;

  logic at_a, at_b;

  always_comb begin
    at_a = (addr == ADDR_A);
    at_b = (addr == ADDR_B);
    tok  = TK_OTHER;
    if (at_a && data == KEY1_DATA)       tok = TK_KEY1;
    else if (at_b && data == KEY2_DATA)  tok = TK_KEY2;
    else if (at_a && data == GRANT_DATA) tok = TK_GRANT;
    else if (at_a && data == EXT_DATA)   tok = TK_EXT;
    else if (at_a && data == DROP_DATA)  tok = TK_DROP;
  end
endmodule

// File: rtl/wpg_window.sv
module wpg_window #(
  parameter int WINDOW_CYCLES = 7500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  output logic expire
);
  localparam int CNT_W = $clog2(WINDOW_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_CYCLES - 1);

  logic             active_q, active_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    expire   = active_q && !stb && (cnt_q == LAST);
    cnt_en   = stb || active_q;
    active_d = active_q;
    cnt_d    = cnt_q;
    if (stb) begin
      active_d = 1'b1;
      cnt_d    = '0;
    end else if (expire) begin
      active_d = 1'b0;
      cnt_d    = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (cnt_en) begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end
endmodule

// File: rtl/wpg_fsm.sv
module wpg_fsm
  import wpg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  tok_t tok,
  input  logic expire,
  input  logic wp_done,
  output logic cmd,
  output logic auth,
  output logic protect
);
  step_t step_q, step_d;
  logic  set_q, set_d, clr_q, clr_d;
  logic  prot_q, prot_d;
  logic  set_req, clr_req;

  // next step
  always_comb begin
    step_d  = step_q;
    cmd     = 1'b0;
    set_req = 1'b0;
    clr_req = 1'b0;
    if (stb) begin
      // mismatch fallback: restart or idle
      if (tok == TK_KEY1) begin
        step_d = ST_K1;
        cmd    = 1'b1;
      end else begin
        step_d = ST_IDLE;
      end
      unique case (step_q)
        ST_K1: if (tok == TK_KEY2) begin
          step_d = ST_K2;
          cmd    = 1'b1;
        end
        ST_K2: if (tok == TK_GRANT) begin
          step_d  = ST_DATA;
          cmd     = 1'b1;
          set_req = 1'b1;
        end else if (tok == TK_EXT) begin
          step_d = ST_D3;
          cmd    = 1'b1;
        end
        ST_D3: if (tok == TK_KEY1) begin
          step_d = ST_D4;
          cmd    = 1'b1;
        end
        ST_D4: if (tok == TK_KEY2) begin
          step_d = ST_D5;
          cmd    = 1'b1;
        end
        ST_D5: if (tok == TK_DROP) begin
          step_d  = ST_DATA;
          cmd     = 1'b1;
          clr_req = 1'b1;
        end
        ST_DATA: begin
          step_d = ST_DATA;
          cmd    = 1'b0;
        end
        default: ;
      endcase
    end else if (expire) begin
      step_d = ST_IDLE;
    end
  end

  // pending change and protect flag
  always_comb begin
    prot_d = prot_q;
    if (wp_done) begin
      if (set_q)      prot_d = 1'b1;
      else if (clr_q) prot_d = 1'b0;
    end
    set_d = wp_done ? 1'b0 : set_q;
    clr_d = wp_done ? 1'b0 : clr_q;
    if (set_req) begin
      set_d = 1'b1;
      clr_d = 1'b0;
    end else if (clr_req) begin
      set_d = 1'b0;
      clr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_IDLE;
      set_q  <= 1'b0;
      clr_q  <= 1'b0;
      prot_q <= 1'b0;
    end else begin
      step_q <= step_d;
      set_q  <= set_d;
      clr_q  <= clr_d;
      prot_q <= prot_d;
    end
  end

  assign auth    = (step_q == ST_DATA);
  assign protect = prot_q;
endmodule

// File: rtl/wp_seq_guard.sv
module wp_seq_guard
  import wpg_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int WINDOW_CYCLES = 7500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              wp_done,
  output logic              cmd_byte,
  output logic              byte_store,
  output logic              load_permit,
  output logic              protect_on
);
  logic [1:0] rs_q;
  logic       rst_n_s;
  tok_t       tok;
  logic       expire, cmd, auth, prot;

  // reset release synchroniser
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  wpg_classify #(.ADDR_W(ADDR_W)) u_cls (
    .addr (wr_addr),
    .data (wr_data),
    .tok  (tok)
  );

  wpg_window #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_win (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .stb    (wr_stb),
    .expire (expire)
  );

  wpg_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .stb     (wr_stb),
    .tok     (tok),
    .expire  (expire),
    .wp_done (wp_done),
    .cmd     (cmd),
    .auth    (auth),
    .protect (prot)
  );

  assign cmd_byte    = cmd;
  assign load_permit = !prot || auth;
  assign byte_store  = wr_stb && !cmd && load_permit;
  assign protect_on  = prot;
endmodule

// File: rtl/wp_seq_guard_chk.sv
module wp_seq_guard_chk
  import wpg_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int WINDOW_CYCLES = 7500
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              wp_done,
  input logic              cmd_byte,
  input logic              byte_store,
  input logic              load_permit,
  input logic              protect_on
);
  localparam logic [63:0]       ALT    = alt_ones(ADDR_W);
  localparam logic [ADDR_W-1:0] ADDR_A = ALT[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] ADDR_B = ~ADDR_A;
  localparam int GW = $clog2(WINDOW_CYCLES + 1);
  localparam logic [GW-1:0] GAP_MAX = GW'(WINDOW_CYCLES);

  logic [GW-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              gap <= GAP_MAX;
    else if (wr_stb)         gap <= '0;
    else if (gap != GAP_MAX) gap <= gap + 1'b1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!protect_on && load_permit));

  // R2
  cmd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_byte |-> (wr_addr == ADDR_A || wr_addr == ADDR_B));

  // R2
  cmd_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_byte |-> (wr_data == KEY1_DATA || wr_data == KEY2_DATA ||
                  wr_data == GRANT_DATA || wr_data == EXT_DATA ||
                  wr_data == DROP_DATA));

  // R2
  cmd_nostore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_byte |-> !byte_store);

  // R3
  protect_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(protect_on) |-> $past(wp_done));

  // R4
  locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (protect_on && !load_permit && wr_stb) |-> !byte_store);

  // R9
  open_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!protect_on && wr_stb && !cmd_byte) |-> byte_store);

  // R8
  window_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gap == GAP_MAX) |-> (load_permit == !protect_on));
endmodule

bind wp_seq_guard wp_seq_guard_chk #(
  .ADDR_W(ADDR_W),
  .WINDOW_CYCLES(WINDOW_CYCLES)
) u_chk (.*);

// File: tb/wp_seq_guard_test.sv
`timescale 1ns/1ps
module wp_seq_guard_test;
  localparam int W = 20;

  logic        clk;
  logic        rst_n;
  logic        wr_stb;
  logic [14:0] wr_addr;
  logic [7:0]  wr_data;
  logic        wp_done;
  logic        cmd_byte, byte_store, load_permit, protect_on;

  int checks = 0;
  int fails  = 0;

  wp_seq_guard #(.ADDR_W(15), .WINDOW_CYCLES(W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .wp_done(wp_done), .cmd_byte(cmd_byte),
    .byte_store(byte_store), .load_permit(load_permit),
    .protect_on(protect_on)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic check(input string tag, input string what,
                       input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic strobe(input logic [14:0] a, input logic [7:0] d,
                        input logic done, input logic ec, input logic es,
                        input string tag);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d; wp_done = done;
    #2;
    check(tag, "cmd_byte", cmd_byte, ec);
    check(tag, "byte_store", byte_store, es);
    @(posedge clk); #1;
    wr_stb = 1'b0; wp_done = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic settle();
    repeat (W + 3) @(negedge clk);
  endtask

  task automatic pulse_done();
    @(negedge clk);
    wp_done = 1'b1;
    @(posedge clk); #1;
    wp_done = 1'b0;
  endtask

  task automatic t_reset();
    #2;
    check("R1", "protect_on", protect_on, 1'b0);
    check("R1", "load_permit", load_permit, 1'b1);
    check("R1", "cmd_byte", cmd_byte, 1'b0);
    check("R1", "byte_store", byte_store, 1'b0);
  endtask

  task automatic t_open_writes();
    strobe(15'h0010, 8'h5A, 1'b0, 1'b0, 1'b1, "R9");
    strobe(15'h5555, 8'hAA, 1'b0, 1'b1, 1'b0, "R2");
    strobe(15'h0007, 8'h99, 1'b0, 1'b0, 1'b1, "R7");
    strobe(15'h2AAA, 8'h55, 1'b0, 1'b0, 1'b1, "R7");
    settle();
  endtask

  task automatic t_arm();
    strobe(15'h5555, 8'hAA, 1'b0, 1'b1, 1'b0, "R2");
    strobe(15'h2AAA, 8'h55, 1'b0, 1'b1, 1'b0, "R2");
    strobe(15'h5555, 8'hA0, 1'b0, 1'b1, 1'b0, "R2");
    settle();
    check("R3", "protect_on before done", protect_on, 1'b0);
    pulse_done();
    check("R3", "protect_on after done", protect_on, 1'b1);
  endtask

  task automatic t_locked();
    check("R4", "load_permit idle", load_permit, 1'b0);
    strobe(15'h0123, 8'h42, 1'b0, 1'b0, 1'b0, "R4");
    strobe(15'h5555, 8'hA0, 1'b0, 1'b0, 1'b0, "R4");
    settle();
  endtask

  task automatic t_auth();
    strobe(15'h5555, 8'hAA, 1'b0, 1'b1, 1'b0, "R5");
    strobe(15'h2AAA, 8'h55, 1'b0, 1'b1, 1'b0, "R5");
    strobe(15'h5555, 8'hA0, 1'b0, 1'b1, 1'b0, "R5");
    check("R5", "load_permit", load_permit, 1'b1);
    strobe(15'h0200, 8'h01, 1'b0, 1'b0, 1'b1, "R5");
    strobe(15'h5555, 8'hAA, 1'b0, 1'b0, 1'b1, "R5");
    strobe(15'h0203, 8'h03, 1'b0, 1'b0, 1'b1, "R5");
    settle();
    check("R8", "load_permit after window", load_permit, 1'b0);
    pulse_done();
    check("R3", "protect_on re-armed", protect_on, 1'b1);
  endtask

  task automatic t_mismatch();
    strobe(15'h5555, 8'hAA, 1'b0, 1'b1, 1'b0, "R7");
    strobe(15'h2AAA, 8'h55, 1'b0, 1'b1, 1'b0, "R7");
    strobe(15'h2AAA, 8'h11, 1'b0, 1'b0, 1'b0, "R7");
    strobe(15'h5555, 8'hA0, 1'b0, 1'b0, 1'b0, "R7");
    settle();
    strobe(15'h5555, 8'hAA, 1'b0, 1'b1, 1'b0, "R7");
    strobe(15'h5555, 8'hAA, 1'b0, 1'b1, 1'b0, "R7");
    strobe(15'h2AAA, 8'h55, 1'b0, 1'b1, 1'b0, "R7");
    strobe(15'h5555, 8'hA0, 1'b0, 1'b1, 1'b0, "R7");
    strobe(15'h0100, 8'h3C, 1'b0, 1'b0, 1'b1, "R7");
    settle();
    pulse_done();
  endtask

  task automatic t_window();
    strobe(15'h5555, 8'hAA, 1'b0, 1'b1, 1'b0, "R8");
    strobe(15'h2AAA, 8'h55, 1'b0, 1'b1, 1'b0, "R8");
    repeat (W - 1) @(negedge clk);
    strobe(15'h5555, 8'hA0, 1'b0, 1'b1, 1'b0, "R8");
    strobe(15'h0300, 8'h66, 1'b0, 1'b0, 1'b1, "R8");
    settle();
    pulse_done();
    strobe(15'h5555, 8'hAA, 1'b0, 1'b1, 1'b0, "R8");
    strobe(15'h2AAA, 8'h55, 1'b0, 1'b1, 1'b0, "R8");
    repeat (W) @(negedge clk);
    strobe(15'h5555, 8'hA0, 1'b0, 1'b0, 1'b0, "R8");
    check("R8", "load_permit late step", load_permit, 1'b0);
    settle();
  endtask

  task automatic t_disable();
    strobe(15'h5555, 8'hAA, 1'b0, 1'b1, 1'b0, "R6");
    strobe(15'h2AAA, 8'h55, 1'b0, 1'b1, 1'b0, "R6");
    strobe(15'h5555, 8'h80, 1'b0, 1'b1, 1'b0, "R6");
    strobe(15'h5555, 8'hAA, 1'b0, 1'b1, 1'b0, "R6");
    strobe(15'h2AAA, 8'h55, 1'b0, 1'b1, 1'b0, "R6");
    strobe(15'h5555, 8'h20, 1'b1, 1'b1, 1'b0, "R10");
    check("R10", "protect_on held", protect_on, 1'b1);
    check("R6", "load_permit", load_permit, 1'b1);
    strobe(15'h0040, 8'h77, 1'b0, 1'b0, 1'b1, "R6");
    settle();
    check("R10", "protect_on before done", protect_on, 1'b1);
    pulse_done();
    check("R6", "protect_on cleared", protect_on, 1'b0);
    strobe(15'h5555, 8'h12, 1'b0, 1'b0, 1'b1, "R9");
    check("R9", "load_permit", load_permit, 1'b1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_stb = 1'b0; wr_addr = '0; wr_data = '0; wp_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_open_writes();
    t_arm();
    t_locked();
    t_auth();
    t_mismatch();
    t_window();
    t_disable();
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule